// File: doc/BRIEF.md
# Lockable Cache Way Replacement Controller

This block keeps the tag state and picks the way for a 32-way set-associative instruction cache in which software can pin lines. Each set holds a valid bit and a tag per way, a count of pinned ways, and a round-robin victim pointer. A request carries a line address, split into a set index in the low bits and a tag above it. The request is either a plain lookup, which allocates on a miss, or a lock, which finds or fills the line and pins it. Separate strobes invalidate one line by address, invalidate every unpinned line, or clear every pin. A global enable turns the whole cache off.

Pinned lines fill the low ways of a set from way 0 upward, in the order they are pinned. The victim pointer moves only through the ways from the pin count up to the top way. At most 28 ways per set may be pinned. A pin request that arrives when a set already holds that many is refused. The line still goes into the cache as an ordinary line, and the pointer is left at the top way. All responses are combinational and reflect the state at the start of the cycle. Every update, including the invalidates, lands on the next clock edge.

Top module: `lockable_way_ctl`

## Requirements
- R1: After reset every line is invalid, every pin count and every pointer is zero, and with no request all response outputs are 0. The first lookup in a set misses and fills way 0.
- R2: A lookup whose tag matches a valid way asserts `respHit` with `respWay` equal to that way, and it changes no state.
- R3: A lookup miss fills the way under the set's pointer and reports it with `respFill`. The pointer then advances by one. From way 31 it wraps to the set's pin count.
- R4: A lock request for an absent line, in a set with fewer than 28 pins, fills way number equal to the pin count. It asserts `lockOk` and `respFill` and adds one to the count. If the pointer is at or below the newly pinned way, it moves to the way just above it.
- R5: A miss never picks a pinned way. Once a set holds N pins, victims cycle through ways N to 31 only.
- R6: A lock request that hits an unpinned line asserts `respHit` and `lockOk` and pins the line at the way given by the pin count. If the line sat in another way, that copy is dropped, the line is refilled into the pin way, and `respFill` is asserted.
- R7: A lock request that hits a pinned line asserts `respHit` and `lockOk`, reports that way, and leaves the count and the pointer unchanged.
- R8: A lock request in a set that already holds 28 pins asserts `lockDrop` and never `lockOk`. On a miss it fills way 31 as an ordinary line. In both the hit and the miss case the set's pointer is left at way 31.
- R9: `invLine` clears the valid bit of the line at `invAddr`, whether or not it is pinned. A lookup in the same cycle still sees the old state, and a lookup in any later cycle sees the line as gone.
- R10: `invAll` clears every unpinned line in all sets and leaves the pinned lines valid.
- R11: `unlockAll` sets every pin count to zero and keeps valid bits and tags. An `invAll` after it then clears every line.
- R12: With `cacheEn` low, a request asserts `respUncached` and none of `respHit`, `respFill`, `lockOk` or `lockDrop`, and it changes no tag, pointer or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cacheEn | input | 1 | Global cache enable |
| reqValid | input | 1 | Request present this cycle |
| reqLock | input | 1 | 1: lock request, 0: plain lookup |
| reqAddr | input | ADDR_W | Line address: set index in the low SET_W bits, tag above |
| invLine | input | 1 | Invalidate the line at invAddr |
| invAddr | input | ADDR_W | Address for invLine |
| invAll | input | 1 | Invalidate every unpinned line |
| unlockAll | input | 1 | Clear every pin count |
| respHit | output | 1 | Request hit a valid line |
| respFill | output | 1 | Request writes a new tag into respWay |
| respWay | output | 5 | Hit way, or the way being filled |
| lockOk | output | 1 | Lock request is granted |
| lockDrop | output | 1 | Lock request is refused because the set is full |
| respUncached | output | 1 | Request is served as non-cacheable |

## Verification
A corrupted pointer or pin count shows up at the very next miss in that set, because `respWay` names the victim in the same cycle as the request. The table tracks the pointer across misses, moved pins, a wrap from way 31, and the pointer forced to 31 after a refused pin. A lost or stale tag appears as a wrong `respHit` on the next lookup of that address. Each invalidate and unlock is therefore followed at once by lookups to lines that must survive and lines that must be gone.

// File: rtl/lockway_pkg.sv
package lockway_pkg;
  localparam int WAYS  = 32;
  localparam int WAY_W = $clog2(WAYS);

  typedef struct packed {
    logic             wrEn;
    logic [WAY_W-1:0] wrWay;
    logic             clrEn;
    logic [WAY_W-1:0] clrWay;
    logic             lockInc;
    logic             ptrEn;
    logic [WAY_W-1:0] ptrVal;
  } lockway_stb_t;
endpackage

// File: rtl/lockway_store.sv
module lockway_store
  import lockway_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int TAG_W  = 8,
  parameter int SET_W  = $clog2(SETS),
  parameter int ADDR_W = TAG_W + SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              invLine,
  input  logic [ADDR_W-1:0] invAddr,
  input  logic              invAll,
  input  logic              unlockAll,
  input  lockway_stb_t      stb,
  output logic              hit,
  output logic [WAY_W-1:0]  hitWay,
  output logic [WAY_W-1:0]  lockCnt,
  output logic [WAY_W-1:0]  ptr
);
  logic [WAYS-1:0]  validQ [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [WAY_W-1:0] lockQ  [SETS];
  logic [WAY_W-1:0] ptrQ   [SETS];

  logic [SET_W-1:0] reqSet, invSet;
  logic [TAG_W-1:0] reqTag, invTag;
  logic [WAYS-1:0]  reqMatch, invMatch;

  assign reqSet = reqAddr[SET_W-1:0];
  assign reqTag = reqAddr[SET_W +: TAG_W];
  assign invSet = invAddr[SET_W-1:0];
  assign invTag = invAddr[SET_W +: TAG_W];

  // one comparator pair per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign reqMatch[w] = validQ[reqSet][w] && (tagQ[reqSet][w] == reqTag);
    assign invMatch[w] = validQ[invSet][w] && (tagQ[invSet][w] == invTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (reqMatch[w]) hitWay = WAY_W'(w);
    end
  end

  assign hit     = |reqMatch;
  assign lockCnt = lockQ[reqSet];
  assign ptr     = ptrQ[reqSet];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        lockQ[s]  <= '0;
        ptrQ[s]   <= '0;
      end
    end else begin
      if (stb.clrEn)   validQ[reqSet][stb.clrWay] <= 1'b0;
      if (stb.wrEn)    validQ[reqSet][stb.wrWay]  <= 1'b1;
      if (stb.lockInc) lockQ[reqSet] <= lockQ[reqSet] + 1'b1;
      if (stb.ptrEn)   ptrQ[reqSet]  <= stb.ptrVal;
      if (invLine) begin
        for (int w = 0; w < WAYS; w++) begin
          if (invMatch[w]) validQ[invSet][w] <= 1'b0;
        end
      end
      if (invAll) begin
        for (int s = 0; s < SETS; s++) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) >= lockQ[s]) validQ[s][w] <= 1'b0;
          end
        end
      end
      if (unlockAll) begin
        for (int s = 0; s < SETS; s++) lockQ[s] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn && !rst) tagQ[reqSet][stb.wrWay] <= reqTag;
  end
endmodule

// File: rtl/lockway_decide.sv
module lockway_decide
  import lockway_pkg::*;
#(
  parameter int LOCK_MAX = 28
) (
  input  logic             reqValid,
  input  logic             reqLock,
  input  logic             cacheEn,
  input  logic             hit,
  input  logic [WAY_W-1:0] hitWay,
  input  logic [WAY_W-1:0] lockCnt,
  input  logic [WAY_W-1:0] ptr,
  output lockway_stb_t     stb,
  output logic             respHit,
  output logic             respFill,
  output logic [WAY_W-1:0] respWay,
  output logic             lockOk,
  output logic             lockDrop,
  output logic             respUncached
);
  localparam logic [WAY_W-1:0] TOP_WAY  = WAY_W'(WAYS - 1);
  localparam logic [WAY_W-1:0] LOCK_LIM = WAY_W'(LOCK_MAX);

  always_comb begin
    stb          = '0;
    respHit      = 1'b0;
    respFill     = 1'b0;
    respWay      = '0;
    lockOk       = 1'b0;
    lockDrop     = 1'b0;
    respUncached = 1'b0;
    if (reqValid) begin
      if (!cacheEn) begin
        respUncached = 1'b1;
      end else if (reqLock) begin
        if (hit && hitWay < lockCnt) begin
          respHit = 1'b1;
          respWay = hitWay;
          lockOk  = 1'b1;
        end else if (lockCnt < LOCK_LIM) begin
          lockOk      = 1'b1;
          respWay     = lockCnt;
          stb.lockInc = 1'b1;
          respHit     = hit;
          if (!hit || hitWay != lockCnt) begin
            stb.wrEn  = 1'b1;
            stb.wrWay = lockCnt;
            respFill  = 1'b1;
            if (hit) begin
              stb.clrEn  = 1'b1;
              stb.clrWay = hitWay;
            end
          end
          if (ptr <= lockCnt) begin
            stb.ptrEn  = 1'b1;
            stb.ptrVal = lockCnt + 1'b1;
          end
        end else begin
          lockDrop   = 1'b1;
          stb.ptrEn  = 1'b1;
          stb.ptrVal = TOP_WAY;
          if (hit) begin
            respHit = 1'b1;
            respWay = hitWay;
          end else begin
            stb.wrEn  = 1'b1;
            stb.wrWay = TOP_WAY;
            respFill  = 1'b1;
            respWay   = TOP_WAY;
          end
        end
      end else if (hit) begin
        respHit = 1'b1;
        respWay = hitWay;
      end else begin
        stb.wrEn   = 1'b1;
        stb.wrWay  = ptr;
        respFill   = 1'b1;
        respWay    = ptr;
        stb.ptrEn  = 1'b1;
        stb.ptrVal = (ptr == TOP_WAY) ? lockCnt : ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockable_way_ctl.sv
module lockable_way_ctl
  import lockway_pkg::*;
#(
  parameter int SETS     = 4,
  parameter int TAG_W    = 8,
  parameter int LOCK_MAX = 28,
  parameter int SET_W    = $clog2(SETS),
  parameter int ADDR_W   = TAG_W + SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cacheEn,
  input  logic              reqValid,
  input  logic              reqLock,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              invLine,
  input  logic [ADDR_W-1:0] invAddr,
  input  logic              invAll,
  input  logic              unlockAll,
  output logic              respHit,
  output logic              respFill,
  output logic [4:0]        respWay,
  output logic              lockOk,
  output logic              lockDrop,
  output logic              respUncached
);
  lockway_stb_t     stb;
  logic             hit;
  logic [WAY_W-1:0] hitWay, lockCnt, ptr;

  lockway_store #(.SETS(SETS), .TAG_W(TAG_W), .SET_W(SET_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .reqAddr(reqAddr), .invLine(invLine), .invAddr(invAddr),
    .invAll(invAll), .unlockAll(unlockAll), .stb(stb),
    .hit(hit), .hitWay(hitWay), .lockCnt(lockCnt), .ptr(ptr)
  );

  lockway_decide #(.LOCK_MAX(LOCK_MAX)) u_decide (
    .reqValid(reqValid), .reqLock(reqLock), .cacheEn(cacheEn),
    .hit(hit), .hitWay(hitWay), .lockCnt(lockCnt), .ptr(ptr), .stb(stb),
    .respHit(respHit), .respFill(respFill), .respWay(respWay),
    .lockOk(lockOk), .lockDrop(lockDrop), .respUncached(respUncached)
  );
endmodule

// File: rtl/lockway_chk.sv
module lockway_chk #(
  parameter int ADDR_W   = 10,
  parameter int LOCK_MAX = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              cacheEn,
  input logic              reqValid,
  input logic              reqLock,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              invLine,
  input logic              invAll,
  input logic              respHit,
  input logic              respFill,
  input logic [4:0]        respWay,
  input logic              lockOk,
  input logic              lockDrop,
  input logic              respUncached
);
  AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lockOk && lockDrop)); // R8

  AST_DROP_TOP_WAY: assert property (@(posedge clk) disable iff (rst)
    lockDrop && respFill |-> respWay == 5'd31); // R8

  AST_PIN_LOW_WAY: assert property (@(posedge clk) disable iff (rst)
    lockOk && respFill |-> respWay < LOCK_MAX); // R4

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    reqValid && !cacheEn |-> respUncached && !respHit && !respFill && !lockOk && !lockDrop); // R12

  AST_LOOKUP_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
    reqValid && !reqLock |-> !lockOk && !lockDrop); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !reqValid |-> !respHit && !respFill && !lockOk && !lockDrop && !respUncached); // R1

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    reqValid && cacheEn && !reqLock &&
    $past(!rst && reqValid && cacheEn && respFill && !invLine && !invAll) &&
    reqAddr == $past(reqAddr) |-> respHit); // R3
endmodule

bind lockable_way_ctl lockway_chk #(.ADDR_W(ADDR_W), .LOCK_MAX(LOCK_MAX)) u_chk (
  .clk(clk), .rst(rst), .cacheEn(cacheEn), .reqValid(reqValid), .reqLock(reqLock),
  .reqAddr(reqAddr), .invLine(invLine), .invAll(invAll), .respHit(respHit),
  .respFill(respFill), .respWay(respWay), .lockOk(lockOk), .lockDrop(lockDrop),
  .respUncached(respUncached)
);

// File: tb/test_lockable_way_ctl.sv
module test_lockable_way_ctl;
  localparam int ADDR_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cacheEn, reqValid, reqLock, invLine, invAll, unlockAll;
  logic [ADDR_W-1:0] reqAddr, invAddr;
  logic respHit, respFill, lockOk, lockDrop, respUncached;
  logic [4:0] respWay;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  lockable_way_ctl i_lockable_way_ctl (
    .clk(clk), .rst(rst), .cacheEn(cacheEn), .reqValid(reqValid), .reqLock(reqLock),
    .reqAddr(reqAddr), .invLine(invLine), .invAddr(invAddr), .invAll(invAll),
    .unlockAll(unlockAll), .respHit(respHit), .respFill(respFill), .respWay(respWay),
    .lockOk(lockOk), .lockDrop(lockDrop), .respUncached(respUncached)
  );

  // op: 0 lookup, 1 lock, 2 invLine, 3 invAll, 4 unlockAll, 5 lookup disabled,
  //     6 lookup plus invLine of the same address
  typedef struct packed {
    logic [2:0] op;
    logic [9:0] addr;
    logic       hit;
    logic       fill;
    logic [4:0] way;
    logic       ok;
    logic       drop;
    logic       unc;
    logic [7:0] req;
  } vec_t;

  // address = tag*4 + set
  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 10'd4,  1'b0, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 first miss way 0
    '{3'd0, 10'd4,  1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 hit
    '{3'd0, 10'd8,  1'b0, 1'b1, 5'd1, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 pointer advanced
    '{3'd1, 10'd12, 1'b0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 pin into way 0
    '{3'd0, 10'd4,  1'b0, 1'b1, 5'd2, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 victim skips pin
    '{3'd1, 10'd8,  1'b1, 1'b0, 5'd1, 1'b1, 1'b0, 1'b0, 8'd6},  // R6 pin in place
    '{3'd0, 10'd16, 1'b0, 1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 8'd3},  // R3
    '{3'd1, 10'd16, 1'b1, 1'b1, 5'd2, 1'b1, 1'b0, 1'b0, 8'd6},  // R6 moved 3 -> 2
    '{3'd0, 10'd4,  1'b0, 1'b1, 5'd4, 1'b0, 1'b0, 1'b0, 8'd5},  // R5
    '{3'd1, 10'd12, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 relock
    '{3'd0, 10'd16, 1'b1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 8'd2},  // R2
    '{3'd6, 10'd16, 1'b1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 8'd9},  // R9 old state seen
    '{3'd0, 10'd16, 1'b0, 1'b1, 5'd5, 1'b0, 1'b0, 1'b0, 8'd9},  // R9 gone next cycle
    '{3'd3, 10'd0,  1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 8'd10},
    '{3'd0, 10'd12, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 8'd10}, // R10 pinned kept
    '{3'd0, 10'd8,  1'b1, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0, 8'd10}, // R10
    '{3'd0, 10'd4,  1'b0, 1'b1, 5'd6, 1'b0, 1'b0, 1'b0, 8'd10}, // R10 unpinned gone
    '{3'd5, 10'd12, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 8'd12}, // R12
    '{3'd5, 10'd20, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 8'd12}, // R12
    '{3'd0, 10'd20, 1'b0, 1'b1, 5'd7, 1'b0, 1'b0, 1'b0, 8'd12}, // R12 no alloc happened
    '{3'd4, 10'd0,  1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 8'd11},
    '{3'd0, 10'd12, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 8'd11}, // R11 valid kept
    '{3'd3, 10'd0,  1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 8'd11},
    '{3'd0, 10'd12, 1'b0, 1'b1, 5'd8, 1'b0, 1'b0, 1'b0, 8'd11}, // R11 all cleared
    '{3'd0, 10'd8,  1'b0, 1'b1, 5'd9, 1'b0, 1'b0, 1'b0, 8'd11}, // R11
    '{3'd0, 10'd5,  1'b0, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 8'd3}   // R3 other set own pointer
  };

  task automatic idle();
    cacheEn = 1'b1; reqValid = 1'b0; reqLock = 1'b0; reqAddr = '0;
    invLine = 1'b0; invAddr = '0; invAll = 1'b0; unlockAll = 1'b0;
  endtask

  task automatic drive(int op, int addr);
    idle();
    case (op)
      0: begin reqValid = 1'b1; reqAddr = ADDR_W'(addr); end
      1: begin reqValid = 1'b1; reqLock = 1'b1; reqAddr = ADDR_W'(addr); end
      2: begin invLine = 1'b1; invAddr = ADDR_W'(addr); end
      3: invAll = 1'b1;
      4: unlockAll = 1'b1;
      5: begin cacheEn = 1'b0; reqValid = 1'b1; reqAddr = ADDR_W'(addr); end
      default: begin
        reqValid = 1'b1; reqAddr = ADDR_W'(addr);
        invLine = 1'b1; invAddr = ADDR_W'(addr);
      end
    endcase
  endtask

  // expected packing: hit, fill, way[4:0], ok, drop, unc
  task automatic check(string req, logic [9:0] exp);
    logic [9:0] act;
    act = {respHit, respFill, respWay, lockOk, lockDrop, respUncached};
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got hit=%b fill=%b way=%0d ok=%b drop=%b unc=%b, expected hit=%b fill=%b way=%0d ok=%b drop=%b unc=%b",
               req, act[9], act[8], act[7:3], act[2], act[1], act[0],
               exp[9], exp[8], exp[7:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // drive at a falling edge, check mid-phase, leave at next falling edge
  task automatic step(int op, int addr, string req, logic [9:0] exp);
    drive(op, addr);
    #2;
    check(req, exp);
    @(negedge clk);
  endtask

  function automatic logic [9:0] pk(bit hit, bit fill, int way, bit ok, bit drop);
    return {hit, fill, 5'(way), ok, drop, 1'b0};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R1 idle after reset", 10'd0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(int'(VECS[i].op), int'(VECS[i].addr), $sformatf("R%0d vector %0d", VECS[i].req, i),
           {VECS[i].hit, VECS[i].fill, VECS[i].way, VECS[i].ok, VECS[i].drop, VECS[i].unc});
    end

    // R3 wrap from way 31 back to the pin count (0) in set 2
    for (int t = 1; t <= 32; t++) step(0, t*4 + 2, "R3 fill sweep", pk(1, 0, 0, 0, 0) & 10'h0 | pk(0, 1, t-1, 0, 0));
    step(0, 33*4 + 2, "R3 wrap to way 0", pk(0, 1, 0, 0, 0));
    step(0, 2*4 + 2,  "R3 survivor hit", pk(1, 0, 1, 0, 0));

    // R4 / R5 / R8 / R7 in set 3
    for (int t = 1; t <= 28; t++) step(1, t*4 + 3, "R4 pin fill", pk(0, 1, t-1, 1, 0));
    for (int t = 29; t <= 32; t++) step(0, t*4 + 3, "R5 victims above pins", pk(0, 1, t-1, 0, 0));
    step(0, 33*4 + 3, "R5 wrap to pin count", pk(0, 1, 28, 0, 0));
    step(1, 40*4 + 3, "R8 refused pin fills top way", pk(0, 1, 31, 0, 1));
    step(0, 41*4 + 3, "R8 pointer left at 31", pk(0, 1, 31, 0, 0));
    step(1, 41*4 + 3, "R8 refused pin on hit", pk(1, 0, 31, 0, 1));
    step(0, 42*4 + 3, "R8 pointer back at 31", pk(0, 1, 31, 0, 0));
    step(1, 1*4 + 3,  "R7 relock in full set", pk(1, 0, 0, 1, 0));
    step(0, 1*4 + 3,  "R7 pinned line still hits", pk(1, 0, 0, 0, 0));

    // R9 plain invalidate of a pinned line, then a lookup next cycle
    step(2, 2*4 + 3, "R9 invLine", 10'd0);
    step(0, 2*4 + 3, "R9 pinned line gone", pk(0, 1, 28, 0, 0));

    // R1 reset in the middle of a run
    rst = 1'b1;
    idle();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    step(0, 12, "R1 miss after reset", pk(0, 1, 0, 0, 0));
    step(0, 12, "R1 hit after refill", pk(1, 0, 0, 0, 0));

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule